// File: doc/BRIEF.md
# Floating-point immediate load unit

This execution unit produces the write-back value for two register-immediate
floating-point operations. It receives a decoded 32-bit instruction word and,
alongside it, the current 64-bit contents of the target register. The first
operation, *move-high*, takes a 16-bit immediate and treats it as the upper half
of a single-format number whose lower half is zero. It widens that number to
double format. The second operation, *patch-low*, narrows the register value to
its single-format image and replaces the lower 16 bits of that image with the
immediate. It then widens the result back to double. Used in sequence, the two
operations build any single-precision constant without a memory load.

Requests enter on a valid/ready stream and results leave on a second valid/ready
stream. There is one result register between the two streams.
- A request is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the result register is empty, or when its content leaves on that same edge (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the result register and `in_ready` stay frozen.

A word whose opcode fields match neither operation still produces a result beat.
That beat has the write enable low.

Top module: `fp_imm_load_unit`

## Requirements
- R1: Instruction bit 31 of the vector is the most significant bit of the word.
  - The major opcode sits in `in_instr[31:26]` and the target register number in `in_instr[25:21]`.
  - The minor opcode sits in `in_instr[5:1]`.
  - The immediate is `{in_instr[15:6], in_instr[20:16], in_instr[0]}`, with the 10-bit field highest.
- R2: With major opcode `MAJOR_OP` (default 22) and minor opcode `XO_MOVE` (default 3), the result is the double conversion of the single value `{imm, 16'h0000}`.
  - `out_wen` is 1.
  - `out_tgt` is the target register field.
- R3: Widening a normal single value keeps the sign, adds 896 to the 8-bit exponent to form the 11-bit exponent, and appends 29 zero bits below the 23-bit fraction. A single zero becomes a double zero of the same sign.
- R4: A single exponent of all ones becomes a double exponent of all ones with the fraction carried over, so infinities stay infinities and NaNs stay NaNs. For example, 0x7FC0 gives 0x7FF8000000000000.
- R5: A single denormal with its leading fraction one at bit p (0 to 22) widens to double exponent 874+p. The fraction is shifted left by 23-p, dropping the leading one.
- R6: With minor opcode `XO_PATCH` (default 11), the register value is narrowed to single format. The low 16 bits of that image are replaced by the immediate, and the result is widened as in R3 to R5 with `out_wen` 1.
  - Narrowing keeps the sign.
  - For a double exponent of 897 or more, narrowing subtracts 896 from the exponent, keeping 8 bits.
  - Narrowing keeps the top 23 fraction bits without rounding.
  - A double exponent of all ones narrows to a single exponent of all ones.
- R7: In narrowing, a double exponent e in the range 874 to 896 gives a single denormal. Its fraction is `{1, top 23 fraction bits}` shifted right by 897-e, keeping the low 23 bits. A smaller exponent, including zero, gives a signed zero.
- R8: A word whose major opcode differs from `MAJOR_OP`, or whose minor opcode is neither `XO_MOVE` nor `XO_PATCH`, gives a result beat with `out_wen` 0 and `out_data` 0.
- R9: A request taken on a clock edge appears on the output from that edge onward, with `out_valid` high. The latency is one cycle.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data`, `out_wen` and `out_tgt` hold their values.
- R11: During and directly after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_instr | input | 32 | Instruction word |
| in_regval | input | 64 | Current contents of the target register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Double-format result |
| out_wen | output | 1 | Result is to be written to the register file |
| out_tgt | output | 5 | Target register number |

## Verification
The bench builds the unit with the default opcode values 22, 3 and 11. It composes its own words from those values, so the legal encodings can be mixed freely with near-miss words. These vary only the major or only the minor field.

With those values, the following are each reached directly:
- the fixed immediates listed for move-high;
- the two-step constant chain;
- single denormals created by patch-low on a zero register;
- doubles in the single-denormal range and below it;
- infinities and NaNs through the narrowing path.

A long random phase toggles `out_ready` to exercise the stall and hold rules under back-pressure.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int IMM_W     = 16;
  localparam int INSTR_W   = 32;
  localparam int REG_W     = 5;
  localparam int FRAC_PAD  = DP_FRAC_W - SP_FRAC_W;           // 29
  localparam int BIAS_DIFF = 1023 - 127;                       // 896
  localparam int DENORM_LO = BIAS_DIFF + 1 - SP_FRAC_W;        // 874
  localparam int NORM_MIN  = BIAS_DIFF + 1;                    // 897

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_MOVE  = 2'd1,
    OP_PATCH = 2'd2
  } fpimm_op_e;

  typedef struct packed {
    fpimm_op_e               op;
    logic [REG_W-1:0]        tgt;
    logic [IMM_W-1:0]        imm;
  } fpimm_dec_t;
endpackage

// File: rtl/fpimm_decode.sv
module fpimm_decode
  import fpimm_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'd22,
  parameter logic [4:0] XO_MOVE  = 5'd3,
  parameter logic [4:0] XO_PATCH = 5'd11
) (
  input  logic [INSTR_W-1:0] instr_i,
  output fpimm_dec_t         dec_o
);
  logic [5:0]  major;
  logic [4:0]  minor;
  logic [9:0]  hi_field;
  logic [4:0]  mid_field;
  logic        lo_field;

  always_comb begin
    major     = instr_i[31:26];
    minor     = instr_i[5:1];
    hi_field  = instr_i[15:6];
    mid_field = instr_i[20:16];
    lo_field  = instr_i[0];
    dec_o.tgt = instr_i[25:21];
    dec_o.imm = {hi_field, mid_field, lo_field};
    dec_o.op  = OP_NONE;
    if (major == MAJOR_OP) begin
      if (minor == XO_MOVE)       dec_o.op = OP_MOVE;
      else if (minor == XO_PATCH) dec_o.op = OP_PATCH;
    end
  end
endmodule

// File: rtl/fpimm_narrow.sv
module fpimm_narrow
  import fpimm_pkg::*;
(
  input  logic [DP_W-1:FRAC_PAD] dp_hi_i,   // sign, exponent, top 23 fraction bits
  output logic [SP_W-1:0]        sp_o
);
  logic                  sgn;
  logic [DP_EXP_W-1:0]   dexp;
  logic [SP_FRAC_W-1:0]  top_frac;
  logic [SP_FRAC_W:0]    mant;
  logic [4:0]            rshift;
  logic [DP_EXP_W-1:0]   rebased;

  always_comb begin
    sgn      = dp_hi_i[DP_W-1];
    dexp     = dp_hi_i[DP_W-2 -: DP_EXP_W];
    top_frac = dp_hi_i[FRAC_PAD +: SP_FRAC_W];
    rebased  = dexp - DP_EXP_W'(BIAS_DIFF);
    rshift   = 5'(DP_EXP_W'(NORM_MIN) - dexp);
    mant     = {1'b1, top_frac} >> rshift;
    if (&dexp) begin
      sp_o = {sgn, {SP_EXP_W{1'b1}}, top_frac};
    end else if (dexp >= DP_EXP_W'(NORM_MIN)) begin
      sp_o = {sgn, rebased[SP_EXP_W-1:0], top_frac};
    end else if (dexp >= DP_EXP_W'(DENORM_LO)) begin
      sp_o = {sgn, {SP_EXP_W{1'b0}}, mant[SP_FRAC_W-1:0]};
    end else begin
      sp_o = {sgn, {(SP_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen
  import fpimm_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  output logic [DP_W-1:0] dp_o
);
  logic                 sgn;
  logic [SP_EXP_W-1:0]  sexp;
  logic [SP_FRAC_W-1:0] sfrac;
  logic [4:0]           lead;
  logic [4:0]           lshift;
  logic [SP_FRAC_W-1:0] nfrac;

  always_comb begin
    sgn   = sp_i[SP_W-1];
    sexp  = sp_i[SP_W-2 -: SP_EXP_W];
    sfrac = sp_i[SP_FRAC_W-1:0];
    lead  = '0;
    for (int i = 0; i < SP_FRAC_W; i++) begin
      if (sfrac[i]) lead = 5'(i);
    end
    lshift = 5'(SP_FRAC_W) - lead;
    nfrac  = sfrac << lshift;
    if (&sexp) begin
      dp_o = {sgn, {DP_EXP_W{1'b1}}, sfrac, {FRAC_PAD{1'b0}}};
    end else if (sexp != '0) begin
      dp_o = {sgn, DP_EXP_W'(sexp) + DP_EXP_W'(BIAS_DIFF), sfrac, {FRAC_PAD{1'b0}}};
    end else if (sfrac != '0) begin
      dp_o = {sgn, DP_EXP_W'(DENORM_LO) + DP_EXP_W'(lead), nfrac, {FRAC_PAD{1'b0}}};
    end else begin
      dp_o = {sgn, {(DP_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fp_imm_load_unit.sv
module fp_imm_load_unit
  import fpimm_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'd22,
  parameter logic [4:0] XO_MOVE  = 5'd3,
  parameter logic [4:0] XO_PATCH = 5'd11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [DP_W-1:0]    in_regval,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DP_W-1:0]    out_data,
  output logic               out_wen,
  output logic [REG_W-1:0]   out_tgt
);
  fpimm_dec_t        dec;
  logic [SP_W-1:0]   narrowed;
  logic [SP_W-1:0]   merged;
  logic [DP_W-1:0]   widened;
  logic              legal;
  logic              take;

  fpimm_decode #(.MAJOR_OP(MAJOR_OP), .XO_MOVE(XO_MOVE), .XO_PATCH(XO_PATCH)) u_dec (
    .instr_i (in_instr),
    .dec_o   (dec)
  );

  fpimm_narrow u_narrow (
    .dp_hi_i (in_regval[DP_W-1:FRAC_PAD]),
    .sp_o    (narrowed)
  );

  always_comb begin
    if (dec.op == OP_PATCH) merged = {narrowed[SP_W-1:IMM_W], dec.imm};
    else                    merged = {dec.imm, {IMM_W{1'b0}}};
  end

  fpimm_widen u_widen (
    .sp_i (merged),
    .dp_o (widened)
  );

  assign legal    = (dec.op != OP_NONE);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_wen   <= 1'b0;
      out_tgt   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= legal ? widened : '0;
        out_wen  <= legal;
        out_tgt  <= dec.tgt;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_wen) && $stable(out_tgt));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_bad_major_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_instr[31:26] != MAJOR_OP) |=> !out_wen && out_data == '0);

  assert_move_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[31:26] == MAJOR_OP && in_instr[5:1] == XO_MOVE
    |=> out_wen && out_data[DP_W-1] == $past(in_instr[15]));

  assert_inf_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[31:26] == MAJOR_OP && in_instr[5:1] == XO_MOVE && (&in_instr[14:7])
    |=> &out_data[62:52]);

  assert_truncate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_instr[5:1] == XO_PATCH && in_regval[FRAC_PAD-1:0] != '0
    |=> out_data[FRAC_PAD-1:0] == '0);
endmodule

// File: tb/sim_fp_imm_load_unit.sv
module sim_fp_imm_load_unit;
  localparam int PERIOD = 10;
  localparam logic [5:0] MJ  = 6'd22;
  localparam logic [4:0] XMV = 5'd3;
  localparam logic [4:0] XPT = 5'd11;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_instr = 0;
  logic [63:0] in_regval = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [63:0] out_data;
  logic        out_wen;
  logic [4:0]  out_tgt;

  fp_imm_load_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_regval(in_regval), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_wen(out_wen), .out_tgt(out_tgt)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [63:0] data;
    logic        wen;
    logic [4:0]  tgt;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t pend;
  bit   last_acc = 0;
  bit   bp_mode  = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // reference conversions, written from the requirements
  function automatic logic [63:0] m_widen(input logic [31:0] x);
    int e = int'(x[30:23]);
    logic [23:0] f = {1'b0, x[22:0]};
    int de;
    if (e == 255) return {x[31], 11'h7FF, x[22:0], 29'd0};
    if (e == 0 && f == 0) return {x[31], 63'd0};
    if (e != 0) begin
      de = e + 896;
      return {x[31], 11'(de), x[22:0], 29'd0};
    end
    de = 897;
    while (!f[23]) begin
      f = f << 1;
      de = de - 1;
    end
    return {x[31], 11'(de), f[22:0], 29'd0};
  endfunction

  function automatic logic [31:0] m_narrow(input logic [63:0] d);
    int e = int'(d[62:52]);
    logic [23:0] m;
    if (e == 2047) return {d[63], 8'hFF, d[51:29]};
    if (e >= 897) return {d[63], 8'(e - 896), d[51:29]};
    if (e >= 874) begin
      m = {1'b1, d[51:29]};
      for (int k = 0; k < 897 - e; k++) m = m >> 1;
      return {d[63], 8'h00, m[22:0]};
    end
    return {d[63], 31'd0};
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] mj, input logic [4:0] xo,
                                     input logic [4:0] t, input logic [15:0] imm);
    return {mj, t, imm[5:1], imm[15:6], xo, imm[0]};
  endfunction

  function automatic exp_t m_result(input logic [31:0] w, input logic [63:0] r, input string tag);
    exp_t e;
    logic [15:0] imm = {w[15:6], w[20:16], w[0]};
    logic [31:0] s;
    e.tgt = w[25:21];
    e.tag = tag;
    if (w[31:26] == MJ && w[5:1] == XMV) begin
      e.data = m_widen({imm, 16'h0});
      e.wen  = 1;
    end else if (w[31:26] == MJ && w[5:1] == XPT) begin
      s = m_narrow(r);
      e.data = m_widen({s[31:16], imm});
      e.wen  = 1;
    end else begin
      e.data = 0;
      e.wen  = 0;
    end
    return e;
  endfunction

  // bookkeeping at the active edge: handshake rule and transfers
  always @(posedge clk) begin
    last_acc = 0;
    if (rst_n) begin
      check(in_ready == ((q.size() == 0) || out_ready), "R10 in_ready", 64'(in_ready),
            64'((q.size() == 0) || out_ready));
      if (out_valid && out_ready && q.size() != 0) void'(q.pop_front());
      if (in_valid && in_ready) begin
        q.push_back(pend);
        last_acc = 1;
      end
    end
  end

  // output comparison away from the edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 0, "R11 reset out_valid", 64'(out_valid), 64'd0);
    end else begin
      check(out_valid == (q.size() != 0), "R9 out_valid", 64'(out_valid), 64'(q.size() != 0));
      if (out_valid && q.size() != 0) begin
        check(out_data == q[0].data, {q[0].tag, " data"}, out_data, q[0].data);
        check(out_wen == q[0].wen, {q[0].tag, " wen"}, 64'(out_wen), 64'(q[0].wen));
        check(out_tgt == q[0].tgt, {q[0].tag, " tgt"}, 64'(out_tgt), 64'(q[0].tgt));
      end
    end
    if (bp_mode) out_ready <= ($urandom % 3) != 0;
    else         out_ready <= 1;
  end

  task automatic send(input logic [31:0] w, input logic [63:0] r, input exp_t e);
    @(negedge clk); #1;
    in_valid  = 1;
    in_instr  = w;
    in_regval = r;
    pend      = e;
    do begin
      @(posedge clk); #1;
    end while (!last_acc);
    in_valid = 0;
  endtask

  task automatic send_k(input logic [31:0] w, input logic [63:0] r, input logic [63:0] d,
                        input logic wen, input string tag);
    exp_t e;
    e.data = d; e.wen = wen; e.tgt = w[25:21]; e.tag = tag;
    send(w, r, e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [63:0] rv;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1/R2/R3: fixed immediates through move-high
    send_k(mk(MJ, XMV, 5'd4, 16'h0000), 64'hDEAD, 64'h0000000000000000, 1, "R3 +0");
    send_k(mk(MJ, XMV, 5'd4, 16'h8000), 0, 64'h8000000000000000, 1, "R3 -0");
    send_k(mk(MJ, XMV, 5'd7, 16'h3F80), 0, 64'h3FF0000000000000, 1, "R2 +1.0");
    send_k(mk(MJ, XMV, 5'd9, 16'hBFC0), 0, 64'hBFF8000000000000, 1, "R1 -1.5 fields");
    send_k(mk(MJ, XMV, 5'd31, 16'h3FFF), 0, 64'h3FFFE00000000000, 1, "R1 1.9921875 low bit");
    // R4
    send_k(mk(MJ, XMV, 5'd1, 16'h7F80), 0, 64'h7FF0000000000000, 1, "R4 +inf");
    send_k(mk(MJ, XMV, 5'd2, 16'hFF80), 0, 64'hFFF0000000000000, 1, "R4 -inf");
    send_k(mk(MJ, XMV, 5'd3, 16'h7FC0), 0, 64'h7FF8000000000000, 1, "R4 qNaN");
    // R6 chain
    send_k(mk(MJ, XPT, 5'd4, 16'h8000), 64'h3FF0000000000000, 64'h3FF0100000000000, 1, "R6 chain");
    send_k(mk(MJ, XPT, 5'd4, 16'h0000), 64'h3FF0000000000FFF, 64'h3FF0000000000000, 1, "R6 truncate");
    send_k(mk(MJ, XPT, 5'd5, 16'h0000), 64'hFFF0000000000000, 64'hFFF0000000000000, 1, "R6 -inf");
    send_k(mk(MJ, XPT, 5'd5, 16'h0001), 64'h7FF8000000000001, 64'h7FF8000020000000, 1, "R6 NaN");
    // R5 denormal widening
    send_k(mk(MJ, XPT, 5'd6, 16'h0001), 64'h0, 64'h36A0000000000000, 1, "R5 min denormal");
    // R7 narrowing of single-denormal range and below
    send_k(mk(MJ, XPT, 5'd6, 16'h1234), 64'h37A0000000000000, 64'h37A1234000000000, 1, "R7 denormal narrow");
    send_k(mk(MJ, XPT, 5'd6, 16'h0000), 64'hB000000000000000, 64'h8000000000000000, 1, "R7 flush");
    // R8
    send_k(mk(6'd23, XMV, 5'd8, 16'h3F80), 0, 64'h0, 0, "R8 bad major");
    send_k(mk(MJ, 5'd4, 5'd8, 16'h3F80), 0, 64'h0, 0, "R8 bad minor");
    drain();

    // random phase with back-pressure (R9, R10)
    bp_mode = 1;
    for (int n = 0; n < 3000; n++) begin
      w = $urandom;
      if (($urandom % 10) != 0) w[31:26] = MJ;
      case ($urandom % 3)
        0: w[5:1] = XMV;
        1: w[5:1] = XPT;
        default: ;
      endcase
      if ($urandom % 2) rv = m_widen($urandom);
      else rv = {$urandom, $urandom};
      send(w, rv, m_result(w, rv, "R10 random"));
      if (($urandom % 4) == 0) @(negedge clk);
    end
    bp_mode = 0;
    drain();
    finish_up();
  end
endmodule